// File: doc/BRIEF.md
# Predicate Mask Lookup Unit

This block turns an operand's register number into the per-element enable mask used by a vectorised or remapped instruction. It owns two small predicate tables, one for integer operands and one for floating-point operands. Each has one entry per 5-bit register number, so the two register classes are predicated independently. An entry records whether predication is on, whether the mask is complemented, whether masked elements are zeroed, and which integer register holds the mask bits.

A request carries the operand class, the register number, the active flag of that operand's remap entry (supplied by the remap logic next door), an element offset and the already-remapped target register number. If both the remap entry and the predicate entry are active, the block issues a read to the integer register file in the same cycle. The register file answers one cycle later. A cycle after that, the block presents the mask (complemented if the invert flag is set) and the zeroing flag. In every other case it presents an all-ones mask with zeroing off. It also reports whether the requested element is enabled, and it returns the target register number for an enabled element or zero for a masked one. Only the active flags are consulted, so a scalar access with an active remap entry is predicated like a vector one.

Top module: `predmask_unit`

## Requirements
- R1: After reset every predicate entry in both tables is inactive, `out_valid` is low and `rf_ren` is low.
- R2: A request whose remap-active input is low yields `out_mask` all ones and `out_zero` low, and it raises no register-file read.
- R3: A request whose remap entry is active but whose predicate entry is inactive yields `out_mask` all ones and `out_zero` low, and it raises no register-file read.
- R4: When both entries are active, `rf_ren` is high and `rf_raddr` equals the entry's source index in the cycle the request is presented, and `out_mask` equals the returned `rf_rdata`.
- R5: When the entry's invert flag is set, `out_mask` is the bitwise complement of the returned register value.
- R6: `out_zero` equals the entry's zeroing flag when predication applies, and it is low whenever the mask defaults to all ones, even if the inactive entry holds a set zeroing flag.
- R7: `out_elem_en` equals bit `req_elem` of `out_mask`. `out_elem_reg` equals `req_tgt` when that bit is 1 and zero when it is 0.
- R8: `cfg_fp`=0 selects the integer table and 1 selects the floating-point table, for writes and for requests. A write to one table leaves the same index in the other table unchanged.
- R9: Results appear with `out_valid` high exactly two clock edges after the edge that samples the request. Requests may be issued on consecutive cycles, and `out_valid` is low in any cycle that has no result two edges back.
- R10: A table write takes effect at the clock edge that samples it. A request sampled at that same edge sees the old entry, and later requests see the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Predicate table write enable |
| cfg_fp | input | 1 | Table select for the write: 0 integer, 1 floating point |
| cfg_idx | input | REG_W | Entry index to write |
| cfg_active | input | 1 | New entry: predication on |
| cfg_inv | input | 1 | New entry: complement the mask |
| cfg_zero | input | 1 | New entry: zero masked elements |
| cfg_src | input | SRC_W | New entry: integer register holding the mask |
| req_valid | input | 1 | Lookup request strobe |
| req_fp | input | 1 | Operand class: 0 integer, 1 floating point |
| req_reg | input | REG_W | Operand register number |
| req_remap_active | input | 1 | Active flag of the operand's remap entry |
| req_elem | input | ELEM_W | Element offset to test |
| req_tgt | input | TGT_W | Remapped target register number |
| rf_ren | output | 1 | Integer register file read strobe |
| rf_raddr | output | SRC_W | Integer register file read address |
| rf_rdata | input | XLEN | Read data, valid one cycle after `rf_ren` |
| out_valid | output | 1 | Result valid |
| out_mask | output | XLEN | Final element enable mask |
| out_zero | output | 1 | Zeroing mode for masked elements |
| out_elem_en | output | 1 | Requested element is enabled |
| out_elem_reg | output | TGT_W | Target register for an enabled element, else zero |

## Verification
A corrupted table entry or a wrong bank select shows up at the ports two edges after the request. It appears as an all-ones mask where register data was expected, or the reverse, and it shows one cycle earlier as a missing or misaddressed `rf_ren`. A flipped invert or zeroing bit in the pipeline gives a complemented mask or a wrong `out_zero` on the very next result. A misaligned element offset shows as `out_elem_en` disagreeing with the mask bit, with `out_elem_reg` not zero on a masked element. Back-to-back requests expose any stage register that holds its value when it should be replaced.

// File: rtl/predmask_pkg.sv
// Shared types for the predicate mask lookup unit.
// Assumes two operand classes, integer and floating point, with one table each.
package predmask_pkg;

    // Control bits of one predicate entry (source index is stored beside it).
    typedef struct packed {
        logic active;
        logic inv;
        logic zero;
    } pred_flags_t;

    localparam int unsigned PM_BANKS = 2;   // bank 0 integer, bank 1 floating point

endpackage

// File: rtl/predmask_bank.sv
// One predicate table bank: NREG entries of flags plus a source register index.
// Write is registered; read is combinational, so a same-cycle read returns the old entry.
// Assumes rd_idx is below NREG.
module predmask_bank
    import predmask_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int REG_W = 5,
    parameter int SRC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_idx,
    input  pred_flags_t      wr_flags,
    input  logic [SRC_W-1:0] wr_src,
    input  logic [REG_W-1:0] rd_idx,
    output pred_flags_t      rd_flags,
    output logic [SRC_W-1:0] rd_src
);

    pred_flags_t      flags_q [NREG];
    logic [SRC_W-1:0] src_q   [NREG];

    // Entry storage: cleared to inactive on reset, one entry written per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                flags_q[i] <= '0;
                src_q[i]   <= '0;
            end
        end else if (wr_en) begin
            flags_q[wr_idx] <= wr_flags;
            src_q[wr_idx]   <= wr_src;
        end
    end

    // Combinational read port.
    always_comb begin
        rd_flags = flags_q[rd_idx];
        rd_src   = src_q[rd_idx];
    end

endmodule

// File: rtl/predmask_issue.sv
// Request stage: decides whether predication applies, raises the register-file
// read, and registers the control that the result stage needs one cycle later.
// Assumes the register file returns data one cycle after rf_ren.
module predmask_issue
    import predmask_pkg::*;
#(
    parameter int ELEM_W = 6,
    parameter int TGT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_remap_active,
    input  pred_flags_t       sel_flags,
    input  logic [ELEM_W-1:0] req_elem,
    input  logic [TGT_W-1:0]  req_tgt,
    output logic              rf_ren,
    output logic              s1_valid,
    output logic              s1_apply,
    output logic              s1_inv,
    output logic              s1_zero,
    output logic [ELEM_W-1:0] s1_elem,
    output logic [TGT_W-1:0]  s1_tgt
);

    logic apply_c;

    // Predication needs both the remap entry and the predicate entry active.
    always_comb begin
        apply_c = req_valid && req_remap_active && sel_flags.active;
        rf_ren  = apply_c;
    end

    // Stage register carrying the decision alongside the pending read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_apply <= 1'b0;
            s1_inv   <= 1'b0;
            s1_zero  <= 1'b0;
            s1_elem  <= '0;
            s1_tgt   <= '0;
        end else begin
            s1_valid <= req_valid;
            if (req_valid) begin
                s1_apply <= apply_c;
                s1_inv   <= sel_flags.inv;
                s1_zero  <= sel_flags.zero;
                s1_elem  <= req_elem;
                s1_tgt   <= req_tgt;
            end
        end
    end

endmodule

// File: rtl/predmask_form.sv
// Result stage: builds the final mask from returned register data, applies the
// invert and zeroing rules, and tests the requested element bit.
// Assumes rf_rdata is valid in the cycle s1_valid and s1_apply are high.
module predmask_form #(
    parameter int XLEN   = 64,
    parameter int ELEM_W = 6,
    parameter int TGT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s1_valid,
    input  logic              s1_apply,
    input  logic              s1_inv,
    input  logic              s1_zero,
    input  logic [ELEM_W-1:0] s1_elem,
    input  logic [TGT_W-1:0]  s1_tgt,
    input  logic [XLEN-1:0]   rf_rdata,
    output logic              out_valid,
    output logic [XLEN-1:0]   out_mask,
    output logic              out_zero,
    output logic              out_elem_en,
    output logic [TGT_W-1:0]  out_elem_reg
);

    logic [XLEN-1:0] mask_c;
    logic            en_c;

    // Mask selection: all ones by default, else register data, optionally complemented.
    always_comb begin
        if (!s1_apply)   mask_c = '1;
        else if (s1_inv) mask_c = ~rf_rdata;
        else             mask_c = rf_rdata;
        en_c = mask_c[s1_elem];
    end

    // Output register; holds the last result between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_mask     <= '1;
            out_zero     <= 1'b0;
            out_elem_en  <= 1'b0;
            out_elem_reg <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_mask     <= mask_c;
                out_zero     <= s1_apply && s1_zero;
                out_elem_en  <= en_c;
                out_elem_reg <= en_c ? s1_tgt : '0;
            end
        end
    end

endmodule

// File: rtl/predmask_unit.sv
// Predicate mask lookup unit top: two predicate tables (integer, floating point),
// the request stage that reads the integer register file, and the result stage.
// Assumes a register file with one-cycle read latency and XLEN a power of two.
module predmask_unit
    import predmask_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int REG_W = 5,
    parameter int SRC_W = 6,
    parameter int TGT_W = 6,
    localparam int NREG   = 1 << REG_W,
    localparam int ELEM_W = $clog2(XLEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_fp,
    input  logic [REG_W-1:0]  cfg_idx,
    input  logic              cfg_active,
    input  logic              cfg_inv,
    input  logic              cfg_zero,
    input  logic [SRC_W-1:0]  cfg_src,
    input  logic              req_valid,
    input  logic              req_fp,
    input  logic [REG_W-1:0]  req_reg,
    input  logic              req_remap_active,
    input  logic [ELEM_W-1:0] req_elem,
    input  logic [TGT_W-1:0]  req_tgt,
    output logic              rf_ren,
    output logic [SRC_W-1:0]  rf_raddr,
    input  logic [XLEN-1:0]   rf_rdata,
    output logic              out_valid,
    output logic [XLEN-1:0]   out_mask,
    output logic              out_zero,
    output logic              out_elem_en,
    output logic [TGT_W-1:0]  out_elem_reg
);

    pred_flags_t      wr_flags;
    pred_flags_t      bank_flags [PM_BANKS];
    logic [SRC_W-1:0] bank_src   [PM_BANKS];
    pred_flags_t      sel_flags;

    logic              s1_valid, s1_apply, s1_inv, s1_zero;
    logic [ELEM_W-1:0] s1_elem;
    logic [TGT_W-1:0]  s1_tgt;

    // Pack the write data for the tables.
    always_comb begin
        wr_flags.active = cfg_active;
        wr_flags.inv    = cfg_inv;
        wr_flags.zero   = cfg_zero;
    end

    for (genvar b = 0; b < PM_BANKS; b++) begin : g_bank
        predmask_bank #(
            .NREG (NREG),
            .REG_W(REG_W),
            .SRC_W(SRC_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_we && (cfg_fp == 1'(b))),
            .wr_idx  (cfg_idx),
            .wr_flags(wr_flags),
            .wr_src  (cfg_src),
            .rd_idx  (req_reg),
            .rd_flags(bank_flags[b]),
            .rd_src  (bank_src[b])
        );
    end

    // Select the bank matching the operand class.
    always_comb begin
        sel_flags = bank_flags[req_fp];
        rf_raddr  = bank_src[req_fp];
    end

    predmask_issue #(
        .ELEM_W(ELEM_W),
        .TGT_W (TGT_W)
    ) u_issue (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_remap_active(req_remap_active),
        .sel_flags       (sel_flags),
        .req_elem        (req_elem),
        .req_tgt         (req_tgt),
        .rf_ren          (rf_ren),
        .s1_valid        (s1_valid),
        .s1_apply        (s1_apply),
        .s1_inv          (s1_inv),
        .s1_zero         (s1_zero),
        .s1_elem         (s1_elem),
        .s1_tgt          (s1_tgt)
    );

    predmask_form #(
        .XLEN  (XLEN),
        .ELEM_W(ELEM_W),
        .TGT_W (TGT_W)
    ) u_form (
        .clk         (clk),
        .rst_n       (rst_n),
        .s1_valid    (s1_valid),
        .s1_apply    (s1_apply),
        .s1_inv      (s1_inv),
        .s1_zero     (s1_zero),
        .s1_elem     (s1_elem),
        .s1_tgt      (s1_tgt),
        .rf_rdata    (rf_rdata),
        .out_valid   (out_valid),
        .out_mask    (out_mask),
        .out_zero    (out_zero),
        .out_elem_en (out_elem_en),
        .out_elem_reg(out_elem_reg)
    );

endmodule

// File: rtl/predmask_unit_chk.sv
// Assertion checker for predmask_unit, attached by bind.
// Tracks request strobe, read strobe and element offset over two edges with its own flops.
module predmask_unit_chk #(
    parameter int XLEN   = 64,
    parameter int ELEM_W = 6,
    parameter int TGT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_remap_active,
    input logic [ELEM_W-1:0] req_elem,
    input logic              rf_ren,
    input logic              out_valid,
    input logic [XLEN-1:0]   out_mask,
    input logic              out_zero,
    input logic              out_elem_en,
    input logic [TGT_W-1:0]  out_elem_reg
);

    logic              v1, v2, ren1, ren2;
    logic [ELEM_W-1:0] e1, e2;

    // Two-edge history of the request side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0; v2 <= 1'b0; ren1 <= 1'b0; ren2 <= 1'b0;
            e1 <= '0;   e2 <= '0;
        end else begin
            v1 <= req_valid;   v2 <= v1;
            ren1 <= rf_ren;    ren2 <= ren1;
            e1 <= req_elem;    e2 <= e1;
        end
    end

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v2);

    p_read_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_ren |-> (req_valid && req_remap_active));

    p_default_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !ren2) |-> (out_mask == {XLEN{1'b1}} && !out_zero));

    p_elem_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_elem_en == out_mask[e2]));

    p_masked_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_elem_en) |-> (out_elem_reg == '0));

endmodule

bind predmask_unit predmask_unit_chk #(
    .XLEN  (XLEN),
    .ELEM_W(ELEM_W),
    .TGT_W (TGT_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_remap_active(req_remap_active),
    .req_elem        (req_elem),
    .rf_ren          (rf_ren),
    .out_valid       (out_valid),
    .out_mask        (out_mask),
    .out_zero        (out_zero),
    .out_elem_en     (out_elem_en),
    .out_elem_reg    (out_elem_reg)
);

// File: tb/predmask_unit_tb.sv
module predmask_unit_tb;

    localparam int XLEN = 64;
    localparam int REG_W = 5;
    localparam int SRC_W = 6;
    localparam int TGT_W = 6;
    localparam int ELEM_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 0, cfg_fp = 0, cfg_active = 0, cfg_inv = 0, cfg_zero = 0;
    logic [REG_W-1:0] cfg_idx = '0;
    logic [SRC_W-1:0] cfg_src = '0;
    logic req_valid = 0, req_fp = 0, req_remap_active = 0;
    logic [REG_W-1:0] req_reg = '0;
    logic [ELEM_W-1:0] req_elem = '0;
    logic [TGT_W-1:0] req_tgt = '0;
    logic rf_ren;
    logic [SRC_W-1:0] rf_raddr;
    logic [XLEN-1:0] rf_rdata = '0;
    logic out_valid, out_zero, out_elem_en;
    logic [XLEN-1:0] out_mask;
    logic [TGT_W-1:0] out_elem_reg;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    predmask_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_fp(cfg_fp), .cfg_idx(cfg_idx), .cfg_active(cfg_active),
        .cfg_inv(cfg_inv), .cfg_zero(cfg_zero), .cfg_src(cfg_src),
        .req_valid(req_valid), .req_fp(req_fp), .req_reg(req_reg),
        .req_remap_active(req_remap_active), .req_elem(req_elem), .req_tgt(req_tgt),
        .rf_ren(rf_ren), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .out_valid(out_valid), .out_mask(out_mask), .out_zero(out_zero),
        .out_elem_en(out_elem_en), .out_elem_reg(out_elem_reg)
    );

    // Register file model: bit k of register i is set when (k + i) mod 3 == 0.
    function automatic logic [XLEN-1:0] rfval(input int i);
        logic [XLEN-1:0] v;
        for (int k = 0; k < XLEN; k++) v[k] = (((k + i) % 3) == 0);
        return v;
    endfunction

    always @(posedge clk) if (rf_ren) rf_rdata <= rfval(int'(rf_raddr));

    // kind: 0 all ones, 1 register data, 2 complemented register data
    function automatic logic [XLEN-1:0] exp_mask(input logic [1:0] kind, input int src);
        if (kind == 2'd0) return '1;
        if (kind == 2'd1) return rfval(src);
        return ~rfval(src);
    endfunction

    task automatic check(input bit ok, input string req, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic fp, input int idx, input logic act,
                             input logic inv, input logic zero, input int src);
        @(negedge clk);
        cfg_we = 1; cfg_fp = fp; cfg_idx = REG_W'(idx); cfg_active = act;
        cfg_inv = inv; cfg_zero = zero; cfg_src = SRC_W'(src);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic set_req(input logic fp, input int rg, input logic remap,
                           input int elem, input int tgt);
        req_valid = 1; req_fp = fp; req_reg = REG_W'(rg); req_remap_active = remap;
        req_elem = ELEM_W'(elem); req_tgt = TGT_W'(tgt);
    endtask

    task automatic check_out(input string req, input logic [1:0] kind, input int src,
                             input logic zero, input int elem, input int tgt);
        logic [XLEN-1:0] m;
        logic en;
        m = exp_mask(kind, src);
        en = m[elem];
        check(out_valid == 1'b1, req, XLEN'(out_valid), 1);
        check(out_mask == m, req, out_mask, m);
        check(out_zero == zero, req, XLEN'(out_zero), XLEN'(zero));
        check(out_elem_en == en, "R7 elem_en", XLEN'(out_elem_en), XLEN'(en));
        check(out_elem_reg == (en ? TGT_W'(tgt) : '0), "R7 elem_reg",
              XLEN'(out_elem_reg), en ? XLEN'(tgt) : '0);
    endtask

    typedef struct packed {
        logic       fp;
        logic [4:0] rg;
        logic       remap;
        logic [5:0] elem;
        logic [5:0] tgt;
        logic [1:0] kind;
        logic [5:0] src;
        logic       zero;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 5'd3,  1'b1, 6'd0,  6'd35, 2'd1, 6'd10, 1'b1},  // R4 R6 direct, masked element
        '{1'b0, 5'd3,  1'b0, 6'd5,  6'd36, 2'd0, 6'd0,  1'b0},  // R2 remap inactive
        '{1'b0, 5'd7,  1'b1, 6'd63, 6'd37, 2'd2, 6'd33, 1'b0},  // R5 inverted
        '{1'b0, 5'd12, 1'b1, 6'd2,  6'd38, 2'd0, 6'd0,  1'b0},  // R3 R6 pred inactive, zero held low
        '{1'b1, 5'd3,  1'b1, 6'd17, 6'd39, 2'd2, 6'd20, 1'b0},  // R8 fp bank inverted
        '{1'b1, 5'd9,  1'b1, 6'd40, 6'd40, 2'd1, 6'd63, 1'b1},  // R8 fp bank direct
        '{1'b1, 5'd7,  1'b1, 6'd4,  6'd41, 2'd0, 6'd0,  1'b0},  // R8 fp 7 inactive
        '{1'b0, 5'd9,  1'b1, 6'd6,  6'd42, 2'd0, 6'd0,  1'b0},  // R8 int 9 inactive
        '{1'b0, 5'd3,  1'b1, 6'd32, 6'd43, 2'd1, 6'd10, 1'b1}   // R4 R7 enabled element
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid", XLEN'(out_valid), 0);
        check(rf_ren == 1'b0, "R1 rf_ren", XLEN'(rf_ren), 0);
        rst_n = 1;

        cfg_write(0, 3, 1, 0, 1, 10);
        cfg_write(0, 7, 1, 1, 0, 33);
        cfg_write(0, 12, 0, 0, 1, 5);
        cfg_write(1, 3, 1, 1, 0, 20);
        cfg_write(1, 9, 1, 0, 1, 63);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            set_req(VECS[i].fp, int'(VECS[i].rg), VECS[i].remap, int'(VECS[i].elem),
                    int'(VECS[i].tgt));
            #1;
            // R4: read strobe and address in the request cycle
            check(rf_ren == (VECS[i].kind != 2'd0), "R4 rf_ren", XLEN'(rf_ren),
                  XLEN'(VECS[i].kind != 2'd0));
            if (VECS[i].kind != 2'd0)
                check(rf_raddr == VECS[i].src, "R4 rf_raddr", XLEN'(rf_raddr), XLEN'(VECS[i].src));
            @(negedge clk);
            req_valid = 0;
            check(out_valid == 1'b0, "R9 not yet valid", XLEN'(out_valid), 0);
            @(negedge clk);
            check_out(VECS[i].kind == 2'd0 ? "R2/R3 default mask" : "R4/R5 register mask",
                      VECS[i].kind, int'(VECS[i].src), VECS[i].zero, int'(VECS[i].elem),
                      int'(VECS[i].tgt));
            @(negedge clk);
            check(out_valid == 1'b0, "R9 drops after one", XLEN'(out_valid), 0);
        end

        // R9: back-to-back requests, results on consecutive cycles
        @(negedge clk); set_req(0, 7, 1, 1, 11);
        @(negedge clk); set_req(1, 9, 1, 0, 12);
        @(negedge clk); req_valid = 0;
        check_out("R9 pipelined first", 2'd2, 33, 1'b0, 1, 11);
        @(negedge clk);
        check_out("R9 pipelined second", 2'd1, 63, 1'b1, 0, 12);

        // R10: write and request in the same cycle sees the old entry
        @(negedge clk);
        cfg_we = 1; cfg_fp = 0; cfg_idx = 5'd20; cfg_active = 1; cfg_inv = 0;
        cfg_zero = 1; cfg_src = 6'd4;
        set_req(0, 20, 1, 2, 13);
        @(negedge clk); cfg_we = 0; req_valid = 0;
        @(negedge clk);
        check_out("R10 old entry", 2'd0, 0, 1'b0, 2, 13);
        @(negedge clk); set_req(0, 20, 1, 2, 14);
        @(negedge clk); req_valid = 0;
        @(negedge clk);
        check_out("R10 new entry", 2'd1, 4, 1'b1, 2, 14);

        // R1: reset clears the tables
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        @(negedge clk); set_req(0, 3, 1, 0, 15);
        #1 check(rf_ren == 1'b0, "R1 table cleared rf_ren", XLEN'(rf_ren), 0);
        @(negedge clk); req_valid = 0;
        @(negedge clk);
        check_out("R1 table cleared", 2'd0, 0, 1'b0, 0, 15);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule